// File: doc/BRIEF.md
# Keyed Configuration Port Register Bank

This block is the configuration front end of a multi-function peripheral chip. A host reaches it through a two-byte I/O window: offset 0 holds an index and offset 1 moves data for that index. The bank stays locked after reset. A host opens it by writing an entry key to the index offset. It then picks one of eight logical devices through a select index and programs that device's registers. These registers are an I/O base, two interrupt numbers, a DMA channel, two mode bytes and an activate flag. Writing an exit key to the index offset locks the bank again.

The programmed contents of every logical device are decoded and driven out as flat configuration vectors, one slice per device. A per-device valid flag follows the activate bit. The peripheral functions themselves (floppy, serial, parallel, keyboard) consume these vectors and are not part of this block. Reads are combinational: `rdata_o` always shows the value behind the current index.

Top module: `cfg_port_bank`

## Requirements
- R1: While locked, a write of 0x55 at offset 0 puts the bank in configuration mode from the next cycle. While in configuration mode, any offset-0 write other than 0xAA loads the index register.
- R2: In configuration mode, a write of 0xAA at offset 0 returns the bank to locked mode. The index and the device selection are kept, and both are visible again after the next 0x55.
- R3: While locked, offset-1 writes change no register, offset-0 writes other than 0x55 leave the index unchanged, and `rdata_o` reads 0xFF.
- R4: In configuration mode, `rdata_o` shows the data for the current index in the same cycle, with no read strobe.
- R5: Index 0x20 reads the constant 0x40, and writes to it have no effect.
- R6: Index 0x07 selects the logical device from data bits 2:0. It reads back as the selection in bits 2:0, with zeros in bits 7:3.
- R7: Indices 0x60 (base high), 0x61 (base low), 0x70 (primary IRQ), 0x72 (secondary IRQ), 0x74 (DMA), 0xF0 (mode 0) and 0xF1 (mode 1) each hold a full byte. A write reaches only the selected device, and the byte reads back unchanged.
- R8: Index 0x30 stores data bit 0 as the activate bit and reads back with bits 7:1 zero. `dev_valid_o[n]` equals device n's activate bit.
- R9: For device n, `dev_base_o[16n+15:16n]` is {base high, base low} and `dev_mode_o[16n+15:16n]` is {mode 1, mode 0}. `dev_irq_a_o`, `dev_irq_b_o` and `dev_dma_o` carry the 8-bit registers at bits [8n+7:8n].
- R10: Indices not listed above read 0x00 in configuration mode, and writes to them change no output.
- R11: After reset the bank is locked, the index and the selection are zero, every device register is zero, and `rdata_o` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the port window |
| addr_i | input | 1 | Port offset: 0 index, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Data for the current index, 0xFF while locked |
| cfg_mode_o | output | 1 | High while in configuration mode |
| dev_valid_o | output | 8 | Per-device activate bit |
| dev_base_o | output | 128 | Per-device 16-bit I/O base |
| dev_irq_a_o | output | 64 | Per-device primary IRQ byte |
| dev_irq_b_o | output | 64 | Per-device secondary IRQ byte |
| dev_dma_o | output | 64 | Per-device DMA byte |
| dev_mode_o | output | 128 | Per-device {mode 1, mode 0} |

## Verification
The assertions check several rules on every cycle. They cover key entry and exit, index and selection holding while locked, the 0xFF read while locked, at most one device write enable, register holding without a write, and the activate bit capturing data bit 0. Other behaviour only the bench scenarios can show. This includes banking the same index across different devices, the masked read-back of the select and activate indices, the constant ID, the silence of unknown indices, and the index surviving an exit and re-entry. The bench runs a behavioural model of the port and compares every output on every cycle.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID      = 8'h20;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ_A   = 8'h70;
  localparam logic [7:0] IDX_IRQ_B   = 8'h72;
  localparam logic [7:0] IDX_DMA     = 8'h74;
  localparam logic [7:0] IDX_MODE0   = 8'hF0;
  localparam logic [7:0] IDX_MODE1   = 8'hF1;

  typedef enum logic [3:0] {
    F_BASE_HI, F_BASE_LO, F_IRQ_A, F_IRQ_B, F_DMA,
    F_MODE0, F_MODE1, F_ACT, F_NONE
  } field_e;

  typedef struct packed {
    logic [7:0] base_hi;
    logic [7:0] base_lo;
    logic [7:0] irq_a;
    logic [7:0] irq_b;
    logic [7:0] dma;
    logic [7:0] mode0;
    logic [7:0] mode1;
    logic       act;
  } dev_cfg_t;

  function automatic field_e decode_index(logic [7:0] idx);
    case (idx)
      IDX_BASE_HI: return F_BASE_HI;
      IDX_BASE_LO: return F_BASE_LO;
      IDX_IRQ_A:   return F_IRQ_A;
      IDX_IRQ_B:   return F_IRQ_B;
      IDX_DMA:     return F_DMA;
      IDX_MODE0:   return F_MODE0;
      IDX_MODE1:   return F_MODE1;
      IDX_ACT:     return F_ACT;
      default:     return F_NONE;
    endcase
  endfunction

  function automatic logic [7:0] field_value(dev_cfg_t c, field_e f);
    case (f)
      F_BASE_HI: return c.base_hi;
      F_BASE_LO: return c.base_lo;
      F_IRQ_A:   return c.irq_a;
      F_IRQ_B:   return c.irq_b;
      F_DMA:     return c.dma;
      F_MODE0:   return c.mode0;
      F_MODE1:   return c.mode1;
      F_ACT:     return {7'd0, c.act};
      default:   return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_ctrl.sv
module cfg_key_ctrl
  import cfg_bank_pkg::*;
#(
  parameter int         LDN_W     = 3,
  parameter logic [7:0] ENTER_KEY = 8'h55,
  parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_idx_i,
  input  logic             wr_dat_i,
  input  logic [7:0]       wdata_i,
  output logic             cfg_mode_o,
  output logic [7:0]       index_o,
  output logic [LDN_W-1:0] ldn_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_mode_o <= 1'b0;
      index_o    <= 8'h00;
      ldn_o      <= '0;
    end else begin
      if (wr_idx_i) begin
        if (!cfg_mode_o) begin
          if (wdata_i == ENTER_KEY) cfg_mode_o <= 1'b1;
        end else if (wdata_i == EXIT_KEY) begin
          cfg_mode_o <= 1'b0;
        end else begin
          index_o <= wdata_i;
        end
      end
      if (wr_dat_i && cfg_mode_o && index_o == IDX_LDN)
        ldn_o <= wdata_i[LDN_W-1:0];
    end
  end

  assert_enter_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx_i && !cfg_mode_o && wdata_i == ENTER_KEY) |=> cfg_mode_o);

  assert_exit_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx_i && cfg_mode_o && wdata_i == EXIT_KEY) |=> (!cfg_mode_o && $stable(index_o)));

  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && (wr_idx_i || wr_dat_i)) |=> ($stable(index_o) && $stable(ldn_o)));

endmodule

// File: rtl/cfg_dev_slot.sv
module cfg_dev_slot
  import cfg_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  field_e     field_i,
  input  logic [7:0] wdata_i,
  output dev_cfg_t   cfg_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (we_i) begin
      case (field_i)
        F_BASE_HI: cfg_o.base_hi <= wdata_i;
        F_BASE_LO: cfg_o.base_lo <= wdata_i;
        F_IRQ_A:   cfg_o.irq_a   <= wdata_i;
        F_IRQ_B:   cfg_o.irq_b   <= wdata_i;
        F_DMA:     cfg_o.dma     <= wdata_i;
        F_MODE0:   cfg_o.mode0   <= wdata_i;
        F_MODE1:   cfg_o.mode1   <= wdata_i;
        F_ACT:     cfg_o.act     <= wdata_i[0];
        default:   ;
      endcase
    end
  end

  assert_act_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && field_i == F_ACT) |=> (cfg_o.act == $past(wdata_i[0])));

  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_o));

endmodule

// File: rtl/cfg_port_bank.sv
module cfg_port_bank
  import cfg_bank_pkg::*;
#(
  parameter int         NUM_DEV   = 8,
  parameter logic [7:0] DEV_ID    = 8'h40,
  parameter logic [7:0] ENTER_KEY = 8'h55,
  parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic                  cfg_mode_o,
  output logic [NUM_DEV-1:0]    dev_valid_o,
  output logic [NUM_DEV*16-1:0] dev_base_o,
  output logic [NUM_DEV*8-1:0]  dev_irq_a_o,
  output logic [NUM_DEV*8-1:0]  dev_irq_b_o,
  output logic [NUM_DEV*8-1:0]  dev_dma_o,
  output logic [NUM_DEV*16-1:0] dev_mode_o
);

  localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             wr_idx, wr_dat;
  logic [7:0]       index;
  logic [LDN_W-1:0] ldn;
  field_e           field;
  logic [NUM_DEV-1:0] dev_we;
  dev_cfg_t         regs [NUM_DEV];
  dev_cfg_t         sel_cfg;

  assign wr_idx = wr_en_i && !addr_i;
  assign wr_dat = wr_en_i && addr_i && cfg_mode_o;
  assign field  = decode_index(index);

  cfg_key_ctrl #(
    .LDN_W(LDN_W), .ENTER_KEY(ENTER_KEY), .EXIT_KEY(EXIT_KEY)
  ) u_key (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_idx_i(wr_idx), .wr_dat_i(wr_dat),
    .wdata_i(wdata_i), .cfg_mode_o(cfg_mode_o), .index_o(index), .ldn_o(ldn)
  );

  for (genvar n = 0; n < NUM_DEV; n++) begin : g_dev
    assign dev_we[n] = wr_dat && (field != F_NONE) && (ldn == LDN_W'(n));

    cfg_dev_slot u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dev_we[n]), .field_i(field),
      .wdata_i(wdata_i), .cfg_o(regs[n])
    );

    assign dev_valid_o[n]         = regs[n].act;
    assign dev_base_o[16*n +: 16] = {regs[n].base_hi, regs[n].base_lo};
    assign dev_irq_a_o[8*n +: 8]  = regs[n].irq_a;
    assign dev_irq_b_o[8*n +: 8]  = regs[n].irq_b;
    assign dev_dma_o[8*n +: 8]    = regs[n].dma;
    assign dev_mode_o[16*n +: 16] = {regs[n].mode1, regs[n].mode0};
  end

  // out-of-range selection (NUM_DEV not a power of two) reads as zero
  always_comb begin
    sel_cfg = '0;
    for (int n = 0; n < NUM_DEV; n++)
      if (ldn == LDN_W'(n)) sel_cfg = regs[n];
  end

  always_comb begin
    if (!cfg_mode_o)            rdata_o = 8'hFF;
    else if (index == IDX_LDN)  rdata_o = 8'(ldn);
    else if (index == IDX_ID)   rdata_o = DEV_ID;
    else                        rdata_o = field_value(sel_cfg, field);
  end

  assert_one_writer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_we));

  assert_locked_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |-> (rdata_o == 8'hFF));

  assert_locked_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && wr_en_i && addr_i) |=>
      ($stable(dev_base_o) && $stable(dev_mode_o) && $stable(dev_valid_o) &&
       $stable(dev_irq_a_o) && $stable(dev_irq_b_o) && $stable(dev_dma_o)));

endmodule

// File: tb/tb_cfg_port_bank.sv
module tb_cfg_port_bank;

  localparam int ND = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic cfg_mode;
  logic [ND-1:0] dev_valid;
  logic [ND*16-1:0] dev_base, dev_mode;
  logic [ND*8-1:0] dev_irq_a, dev_irq_b, dev_dma;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_port_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cfg_mode_o(cfg_mode), .dev_valid_o(dev_valid),
    .dev_base_o(dev_base), .dev_irq_a_o(dev_irq_a), .dev_irq_b_o(dev_irq_b),
    .dev_dma_o(dev_dma), .dev_mode_o(dev_mode)
  );

  // behavioural reference model
  bit         m_cfg;
  logic [7:0] m_idx;
  int         m_ldn;
  logic [7:0] m_mem [ND][256];

  function automatic bit is_dev_idx(logic [7:0] i);
    return i inside {8'h30, 8'h60, 8'h61, 8'h70, 8'h72, 8'h74, 8'hF0, 8'hF1};
  endfunction

  function automatic logic [7:0] exp_rdata();
    if (!m_cfg) return 8'hFF;
    if (m_idx == 8'h07) return 8'(m_ldn);
    if (m_idx == 8'h20) return 8'h40;
    if (is_dev_idx(m_idx)) return m_mem[m_ldn][m_idx];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_idx = 0; m_ldn = 0;
      for (int d = 0; d < ND; d++)
        for (int i = 0; i < 256; i++) m_mem[d][i] = 8'h00;
    end else if (wr_en) begin
      if (!addr) begin
        if (!m_cfg) begin
          if (wdata == 8'h55) m_cfg = 1;
        end else if (wdata == 8'hAA) m_cfg = 0;
        else m_idx = wdata;
      end else if (m_cfg) begin
        if (m_idx == 8'h07) m_ldn = int'(wdata & 8'h07);
        else if (is_dev_idx(m_idx))
          m_mem[m_ldn][m_idx] = (m_idx == 8'h30) ? (wdata & 8'h01) : wdata;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 rdata", 32'(rdata), 32'(exp_rdata()));
      chk("R1 cfg_mode", 32'(cfg_mode), 32'(m_cfg));
      for (int d = 0; d < ND; d++) begin
        chk("R8 valid", 32'(dev_valid[d]), 32'(m_mem[d][8'h30][0]));
        chk("R9 base", 32'(dev_base[16*d +: 16]), 32'({m_mem[d][8'h60], m_mem[d][8'h61]}));
        chk("R9 irq_a", 32'(dev_irq_a[8*d +: 8]), 32'(m_mem[d][8'h70]));
        chk("R9 irq_b", 32'(dev_irq_b[8*d +: 8]), 32'(m_mem[d][8'h72]));
        chk("R9 dma", 32'(dev_dma[8*d +: 8]), 32'(m_mem[d][8'h74]));
        chk("R9 mode", 32'(dev_mode[16*d +: 16]), 32'({m_mem[d][8'hF1], m_mem[d][8'hF0]}));
      end
    end
  end

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    wr(1'b0, idx);
    wr(1'b1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdata", 32'(rdata), 32'hFF);
    chk("R11 cfg_mode", 32'(cfg_mode), 0);
    chk("R11 base", 32'(dev_base[31:0]), 0);
    chk("R11 valid", 32'(dev_valid), 0);

    // R3 locked: writes ignored, only 0x55 recognised
    wr(1'b1, 8'h12);
    wr(1'b0, 8'h07);
    wr(1'b0, 8'hAA);
    chk("R3 locked cfg", 32'(cfg_mode), 0);
    chk("R3 locked rdata", 32'(rdata), 32'hFF);
    chk("R3 locked base", 32'(dev_base), 0);

    // R1 entry; index still 0 so R10 unknown index reads 0
    wr(1'b0, 8'h55);
    chk("R1 entered", 32'(cfg_mode), 1);
    chk("R10 idx0 read", 32'(rdata), 0);

    // R5 ID constant, write ignored
    wr(1'b0, 8'h20);
    chk("R5 id", 32'(rdata), 32'h40);
    wr(1'b1, 8'h99);
    chk("R5 id after write", 32'(rdata), 32'h40);

    // R6 select device with masked readback
    reg_wr(8'h07, 8'h03);
    chk("R6 select", 32'(rdata), 3);
    wr(1'b1, 8'hFB);
    chk("R6 masked select", 32'(rdata), 3);

    // R7 R8 R9 program device 3
    reg_wr(8'h60, 8'h03);
    reg_wr(8'h61, 8'h78);
    reg_wr(8'h70, 8'h07);
    chk("R7 irq readback", 32'(rdata), 7);
    reg_wr(8'hF1, 8'h02);
    reg_wr(8'h30, 8'h01);
    chk("R9 dev3 base", 32'(dev_base[48 +: 16]), 32'h0378);
    chk("R8 dev3 valid", 32'(dev_valid[3]), 1);

    // device 4: activate with 0xFF reads back 0x01
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h60, 8'h03);
    reg_wr(8'h61, 8'hF8);
    reg_wr(8'h70, 8'h04);
    reg_wr(8'h30, 8'hFF);
    chk("R8 act readback", 32'(rdata), 1);
    chk("R9 dev4 base", 32'(dev_base[64 +: 16]), 32'h03F8);

    // device 0: dma, mode, secondary irq; device 3 untouched
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h74, 8'h02);
    reg_wr(8'hF0, 8'h05);
    reg_wr(8'h72, 8'h0C);
    chk("R9 dev0 dma", 32'(dev_dma[7:0]), 2);
    chk("R9 dev0 mode", 32'(dev_mode[15:0]), 32'h0005);
    chk("R7 dev3 unchanged", 32'(dev_base[48 +: 16]), 32'h0378);
    reg_wr(8'h30, 8'h00);
    chk("R8 dev0 inactive", 32'(dev_valid[0]), 0);

    // R10 unknown index in config mode
    reg_wr(8'h55, 8'h77);
    chk("R10 unknown idx", 32'(rdata), 0);
    chk("R1 0x55 as index keeps mode", 32'(cfg_mode), 1);

    // R2 exit, locked write, re-entry keeps index and selection
    reg_wr(8'h07, 8'h04);
    wr(1'b0, 8'h61);
    wr(1'b0, 8'hAA);
    chk("R2 exited", 32'(cfg_mode), 0);
    chk("R2 locked read", 32'(rdata), 32'hFF);
    wr(1'b1, 8'h11);
    chk("R3 locked write ignored", 32'(dev_base[64 +: 16]), 32'h03F8);
    wr(1'b0, 8'h55);
    chk("R2 index kept", 32'(rdata), 32'hF8);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule